// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block stores the eight 16-bit general registers of a small 16-bit processor core: AX, CX, DX, BX, SP, BP, SI and DI. The first four of them can also be reached half by half. Each of them has a low-byte name (AL, CL, DL, BL) and a high-byte name (AH, CH, DH, BH). A byte access touches only its own half of the word, and the other half is left as it was.

The block has one combinational read port and one write port, each addressed by a 4-bit selector. The write port updates the register on the rising clock edge. The read port returns a 16-bit value and zero-extends any byte selection. A plain flag next to the read data tells the execution datapath whether the read selector names a byte register or a word register. The datapath uses this flag to pick the operand width, for example to choose bit 7 or bit 15 as the sign bit.

Selector encoding: values 0 to 3 are AL, CL, DL, BL. Values 4 to 7 are AH, CH, DH, BH. Values 8 to 15 are AX, CX, DX, BX, SP, BP, SI, DI. Every 4-bit value is legal.

Top module: `gpr_bytealias_file`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all eight registers to 0000h, so every selector reads 0000h afterwards.
- R2: Word selectors 8 to 15 name AX, CX, DX, BX, SP, BP, SI and DI in that order. A word write stores all 16 bits of `wr_data`, and a word read returns all 16 bits.
- R3: Selectors 0 to 3 read bits 7:0 of AX, CX, DX and BX in that order, placed in `rd_data[7:0]`, with `rd_data[15:8]` equal to zero.
- R4: Selectors 4 to 7 read bits 15:8 of AX, CX, DX and BX in that order, placed in `rd_data[7:0]`, with `rd_data[15:8]` equal to zero.
- R5: A low-byte write (selectors 0 to 3) replaces bits 7:0 of the aliased word with `wr_data[7:0]` and keeps bits 15:8 unchanged. `wr_data[15:8]` has no effect.
- R6: A high-byte write (selectors 4 to 7) replaces bits 15:8 of the aliased word with `wr_data[7:0]` and keeps bits 7:0 unchanged. `wr_data[15:8]` has no effect.
- R7: `rd_is_byte` is 1 when `rd_sel` is 0 to 7 and 0 when `rd_sel` is 8 to 15.
- R8: A write changes only the register that its selector names. When `wr_en` is low, no register changes.
- R9: Reads are combinational from stored state. A read of the register being written in the same cycle returns the old value, and the new value appears after the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 4 | Write register selector |
| wr_data | input | 16 | Write data; only bits 7:0 are used for byte selectors |
| rd_sel | input | 4 | Read register selector |
| rd_data | output | 16 | Read data, zero-extended for byte selectors |
| rd_is_byte | output | 1 | 1 when `rd_sel` names a byte register |

## Verification
The bound checker checks four things on every cycle. It checks the byte flag and the zero upper half of byte reads. It checks that a write of any width can be read back one cycle later through the same selector. It checks that reads return zero just after reset. Only the bench's scenarios can show that a byte write leaves the other half of its word intact, and that the unused upper write bits are ignored. The same applies to writes leaving unrelated registers alone and to a disabled write having no effect. Each of these needs a chain of earlier writes whose combined result is known.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int GPR_SEL_W   = 4;
  localparam int GPR_IDX_W   = 3;
  localparam int GPR_NUM     = 1 << GPR_IDX_W;
  localparam int GPR_NUM_SPLIT = GPR_NUM / 2;

  // Decoded form of a selector
  typedef struct packed {
    logic                 is_word;  // selector names a whole word
    logic                 is_high;  // byte selector names the upper half
    logic [GPR_IDX_W-1:0] idx;      // physical word index
  } gpr_slot_t;
endpackage

// File: rtl/gpr_sel_decode.sv
module gpr_sel_decode
  import gpr_pkg::*;
(
  input  logic [GPR_SEL_W-1:0] sel,
  output gpr_slot_t            slot
);
  localparam int BYTE_IDX_W = GPR_IDX_W - 1;

  always_comb begin
    slot.is_word = sel[GPR_SEL_W-1];
    slot.is_high = 1'b0;
    slot.idx     = sel[GPR_IDX_W-1:0];
    if (!sel[GPR_SEL_W-1]) begin
      // byte selectors alias the first half of the word registers
      slot.is_high = sel[GPR_IDX_W-1];
      slot.idx     = {1'b0, sel[BYTE_IDX_W-1:0]};
    end
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store
  import gpr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  gpr_slot_t                      wr_slot,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [GPR_NUM-1:0][DATA_W-1:0] regs
);
  localparam int HALF_W = DATA_W / 2;

  // Upper half source: full word data, or the byte lane for high-byte writes
  logic [HALF_W-1:0] hi_src;
  assign hi_src = wr_slot.is_word ? wr_data[DATA_W-1:HALF_W] : wr_data[HALF_W-1:0];

  for (genvar i = 0; i < GPR_NUM; i++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_slot.idx == GPR_IDX_W'(i));

    if (i < GPR_NUM_SPLIT) begin : g_split
      logic lo_we, hi_we;
      assign lo_we = hit && (wr_slot.is_word || !wr_slot.is_high);
      assign hi_we = hit && (wr_slot.is_word ||  wr_slot.is_high);

      always_ff @(posedge clk) begin
        if (rst) begin
          regs[i] <= '0;
        end else begin
          if (lo_we) regs[i][HALF_W-1:0]      <= wr_data[HALF_W-1:0];
          if (hi_we) regs[i][DATA_W-1:HALF_W] <= hi_src;
        end
      end
    end else begin : g_whole
      logic we;
      assign we = hit && wr_slot.is_word;

      always_ff @(posedge clk) begin
        if (rst)     regs[i] <= '0;
        else if (we) regs[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/gpr_read_mux.sv
module gpr_read_mux
  import gpr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [GPR_NUM-1:0][DATA_W-1:0] regs,
  input  gpr_slot_t                      rd_slot,
  output logic [DATA_W-1:0]              rd_data
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] word;
  assign word = regs[rd_slot.idx];

  always_comb begin
    if (rd_slot.is_word)
      rd_data = word;
    else if (rd_slot.is_high)
      rd_data = {{HALF_W{1'b0}}, word[DATA_W-1:HALF_W]};
    else
      rd_data = {{HALF_W{1'b0}}, word[HALF_W-1:0]};
  end
endmodule

// File: rtl/gpr_bytealias_file.sv
module gpr_bytealias_file
  import gpr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [GPR_SEL_W-1:0] wr_sel,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [GPR_SEL_W-1:0] rd_sel,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_is_byte
);
  gpr_slot_t wr_slot, rd_slot;
  logic [GPR_NUM-1:0][DATA_W-1:0] regs;

  gpr_sel_decode u_wdec (.sel(wr_sel), .slot(wr_slot));
  gpr_sel_decode u_rdec (.sel(rd_sel), .slot(rd_slot));

  gpr_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_data(wr_data), .regs(regs)
  );

  gpr_read_mux #(.DATA_W(DATA_W)) u_rmux (
    .regs(regs), .rd_slot(rd_slot), .rd_data(rd_data)
  );

  assign rd_is_byte = !rd_slot.is_word;
endmodule

// File: rtl/gpr_bytealias_file_chk.sv
module gpr_bytealias_file_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [3:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [3:0]        rd_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_is_byte
);
  localparam int HALF_W = DATA_W / 2;

  // R7: width flag follows the selector range
  a_r7_byte_flag: assert property (@(posedge clk) disable iff (rst)
    rd_is_byte == (rd_sel < 4'd8));

  // R3 / R4: byte reads carry a zero upper half
  a_r3_byte_zero_ext: assert property (@(posedge clk) disable iff (rst)
    rd_is_byte |-> (rd_data[DATA_W-1:HALF_W] == '0));

  // R1: right after a reset edge every read is zero
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (rd_data == '0));

  // R2: a word write is visible next cycle through the same selector
  a_r2_word_readback: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel[3]) |=>
      ((rd_sel != $past(wr_sel)) || (rd_data == $past(wr_data))));

  // R5 / R6: a byte write is visible next cycle through the same byte selector
  a_r5_byte_readback: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel[3]) |=>
      ((rd_sel != $past(wr_sel)) ||
       (rd_data == {{HALF_W{1'b0}}, $past(wr_data[HALF_W-1:0])})));
endmodule

bind gpr_bytealias_file gpr_bytealias_file_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_sel(rd_sel), .rd_data(rd_data), .rd_is_byte(rd_is_byte)
);

// File: tb/gpr_bytealias_file_test.sv
module gpr_bytealias_file_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        rd_is_byte;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  gpr_bytealias_file uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .rd_is_byte(rd_is_byte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        we;
    logic [3:0]  ws;
    logic [15:0] wd;
    logic [3:0]  rs;
    logic [15:0] ex;   // expected read before this cycle's write lands
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd8,  16'h1234, 4'd8,  16'h0000}, // R9: AX read while written
    '{1'b1, 4'd9,  16'hABCD, 4'd8,  16'h1234}, // R2
    '{1'b1, 4'd0,  16'hFF77, 4'd9,  16'hABCD}, // AL write
    '{1'b1, 4'd5,  16'h3399, 4'd8,  16'h1277}, // R5: upper kept, FF ignored
    '{1'b0, 4'd8,  16'hFFFF, 4'd9,  16'h99CD}, // R6: CH merged
    '{1'b1, 4'd15, 16'h8001, 4'd8,  16'h1277}, // R8: disabled write
    '{1'b1, 4'd3,  16'h0055, 4'd15, 16'h8001}, // R2: DI
    '{1'b1, 4'd7,  16'h00AA, 4'd3,  16'h0055}, // R3: BL
    '{1'b0, 4'd0,  16'h0000, 4'd11, 16'hAA55}, // R6: BX merged
    '{1'b0, 4'd0,  16'h0000, 4'd7,  16'h00AA}, // R4: BH
    '{1'b0, 4'd0,  16'h0000, 4'd0,  16'h0077}, // R3: AL
    '{1'b0, 4'd0,  16'h0000, 4'd4,  16'h0012}, // R4: AH
    '{1'b0, 4'd0,  16'h0000, 4'd5,  16'h0099}, // R4: CH
    '{1'b0, 4'd0,  16'h0000, 4'd1,  16'h00CD}, // R3: CL
    '{1'b0, 4'd0,  16'h0000, 4'd10, 16'h0000}, // R8: DX untouched
    '{1'b0, 4'd0,  16'h0000, 4'd12, 16'h0000}  // R8: SP untouched
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // Vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr_en = VECS[v].we; wr_sel = VECS[v].ws; wr_data = VECS[v].wd;
      rd_sel = VECS[v].rs;
      #1;
      check($sformatf("vector %0d data", v), rd_data, VECS[v].ex);
      check($sformatf("R7 vector %0d flag", v), {15'b0, rd_is_byte},
            {15'b0, (VECS[v].rs < 4'd8)});
    end

    // R2: every word register holds a distinct full value
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 4'(8 + i); wr_data = 16'(i + 1) * 16'h1111;
    end
    @(negedge clk);
    wr_en = 1'b0;
    for (int i = 0; i < 8; i++) begin
      rd_sel = 4'(8 + i);
      #1;
      check("R2 word readback", rd_data, 16'(i + 1) * 16'h1111);
    end

    // R1: reset clears everything, R7 flag over all selectors
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < 16; s++) begin
      rd_sel = 4'(s);
      #1;
      check("R1 cleared", rd_data, 16'h0000);
      check("R7 flag", {15'b0, rd_is_byte}, {15'b0, (s < 8)});
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule